// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is one 32-bit timer channel. A live counter steps down by one on each pulse of a count enable. The count enable comes from a power-of-four divider of the peripheral clock, and the count runs only while the `start` input is high. When the counter is already zero on a count pulse, it loads the value held in a separate reload register instead of stepping down, and it sets a sticky underflow flag. The interrupt line is high while that flag and the interrupt-enable control bit are both set.

Software reaches three word registers through a plain strobe port: the reload constant at address 0, the live counter at address 1 and the control register at address 2. Address 3 reads as zero and ignores writes. The flag is cleared only by a control write that carries a zero in bit 8. A one in that bit leaves the flag as it is, so a read-modify-write of the other control bits cannot clear an underflow that software has not yet seen.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset the reload register and the counter both read 0xFFFFFFFF, the control register reads 0 and `irq` is low.
- R2: Control bits [2:0] give the divide ratio 4^(sel+1) for sel = 0..4 (4, 16, 64, 256, 1024). The divider is held cleared while `start` is low, so the first count step falls on the div-th rising edge at which `start` is high, and one step follows every div edges after that.
- R3: Select values 5, 6 and 7 produce no count pulses, and the counter holds its value.
- R4: The counter changes only on a count pulse while `start` is high, or on a write to it. With `start` low it holds its value.
- R5: A count pulse that finds the counter at 0 loads the reload value into the counter and sets the underflow flag.
- R6: A write to address 0 sets the reload value. A write to address 1 loads the counter directly. Address 3 reads as 0 and ignores writes.
- R7: Control bit 5 is the interrupt enable. `irq` is high exactly when the flag and bit 5 are both 1.
- R8: A control write with wdata[8] = 0 clears the flag. A control write with wdata[8] = 1 neither sets nor clears it.
- R9: A control read returns stored bits [7:0], the flag in bit 8 and zeros in bits [31:9], whatever was written to those upper bits.
- R10: If an underflow and a register write fall in the same cycle, the flag is set even when the write is a control write carrying a clearing zero, and the counter takes the written value.
- R11: `rdata` is registered. It presents the addressed register as it stood before the rising edge that samples `rd_en`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Count run enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 reload, 1 counter, 2 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, flag AND enable |

## Verification
A write takes effect at the rising edge that samples its strobe. Read data appears one edge after `rd_en` is sampled, and the bench samples it 1 ns after that edge. A count step lands on the div-th edge with `start` high, so each vector holds `start` high for an exact number of edges, drops it between edges, and predicts the count as floor(edges/div) steps with reload on each zero. The collision cases place the write strobe on the 4th edge of a divide-by-4 run with the counter at 0, which is the edge carrying the underflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned IE_BIT     = 5;
  localparam int unsigned FLAG_BIT   = 8;
  localparam int unsigned CTRL_KEEP  = 8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned STEPS = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             ce
);
  localparam int unsigned DIV_W = 2 * STEPS;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             sel_ok;

  assign sel_ok = (32'(sel) < STEPS);

  always_comb begin
    mask = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (32'(sel) == i) mask = DIV_W'((64'd1 << (2 * (i + 1))) - 64'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !start) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  assign ce = start && sel_ok && ((div_q & mask) == mask);

  // R3
  reserved_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(sel) >= STEPS) |-> !ce);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             wr_rel,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] reload,
  output logic             uf
);
  logic [CNT_W-1:0] cnt_q, rel_q;

  assign uf = ce && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      rel_q <= '1;
    end else begin
      if (wr_rel) rel_q <= wdata;
      if (wr_cnt)    cnt_q <= wdata;
      else if (uf)   cnt_q <= rel_q;
      else if (ce)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign reload = rel_q;

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !wr_cnt) |=> $stable(cnt_q));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && cnt_q == '0 && !wr_cnt) |=> (cnt_q == $past(rel_q)));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned KEEP     = 8,
  parameter int unsigned IE_BIT   = 5,
  parameter int unsigned FLAG_BIT = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uf,
  output logic [SEL_W-1:0]  sel,
  output logic              ie,
  output logic              flag,
  output logic [DATA_W-1:0] view
);
  logic [KEEP-1:0] ctl_q;
  logic            flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr) ctl_q <= wdata[KEEP-1:0];
      if (uf)                        flag_q <= 1'b1;
      else if (wr && !wdata[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    view           = '0;
    view[KEEP-1:0] = ctl_q;
    view[FLAG_BIT] = flag_q;
  end

  assign sel  = ctl_q[SEL_W-1:0];
  assign ie   = ctl_q[IE_BIT];
  assign flag = flag_q;

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(uf));
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[FLAG_BIT] && !uf) |=> (flag_q == $past(flag_q)));
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[FLAG_BIT] && !uf) |=> !flag_q);
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned STEPS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  import tmr_pkg::*;

  logic             ce, uf, ie, flag;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt, reload;
  logic [31:0]      ctl_view;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;

  tmr_prescale #(.STEPS(STEPS), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .start(start), .sel(sel), .ce(ce)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ce(ce),
    .wr_rel(wr_en && addr == A_RELOAD),
    .wr_cnt(wr_en && addr == A_COUNT),
    .wdata(wdata[CNT_W-1:0]),
    .cnt(cnt), .reload(reload), .uf(uf)
  );

  tmr_ctrl #(.SEL_W(SEL_W), .KEEP(CTRL_KEEP), .IE_BIT(IE_BIT),
             .FLAG_BIT(FLAG_BIT), .DATA_W(32)) u_ctl (
    .clk(clk), .rst(rst), .wr(wr_en && addr == A_CTRL), .wdata(wdata),
    .uf(uf), .sel(sel), .ie(ie), .flag(flag), .view(ctl_view)
  );

  always_comb begin
    case (addr)
      A_RELOAD: rd_mux = 32'(reload);
      A_COUNT:  rd_mux = 32'(cnt);
      A_CTRL:   rd_mux = ctl_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign irq   = flag & ie;

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: tb/tb_tmr_chan_top.sv
module tb_tmr_chan_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  tmr_chan_top dut (.clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  // fields: sel(3) ie(1) count(32) reload(32) edges(16) exp_count(32) exp_flag(1)
  localparam int NV = 7;
  localparam logic [116:0] VEC [NV] = '{
    {3'd0, 1'b1, 32'd10, 32'd50, 16'd20,   32'd5,  1'b0},
    {3'd1, 1'b1, 32'd3,  32'd9,  16'd64,   32'd9,  1'b1},
    {3'd2, 1'b0, 32'd1,  32'd7,  16'd128,  32'd7,  1'b1},
    {3'd3, 1'b1, 32'd5,  32'd5,  16'd255,  32'd5,  1'b0},
    {3'd4, 1'b1, 32'd0,  32'd3,  16'd1024, 32'd3,  1'b1},
    {3'd5, 1'b1, 32'd2,  32'd2,  16'd100,  32'd2,  1'b0},
    {3'd0, 1'b0, 32'd2,  32'd1,  16'd40,   32'd0,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0; d = rdata;
  endtask

  task automatic run(input int edges);
    @(negedge clk); start = 1'b1;
    repeat (edges) @(posedge clk);
    #1 start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(2'd0, rv); chk("R1 reload", rv, 32'hFFFF_FFFF);
    rd(2'd1, rv); chk("R1 count", rv, 32'hFFFF_FFFF);
    rd(2'd2, rv); chk("R1 ctrl", rv, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 R3 R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] sel; logic ie; logic [31:0] n0, r0, ec; logic [15:0] w; logic ef;
      {sel, ie, n0, r0, w, ec, ef} = VEC[i];
      wr(2'd2, {26'd0, ie, 2'b00, sel});
      wr(2'd0, r0);
      wr(2'd1, n0);
      run(int'(w));
      rd(2'd1, rv); chk("R2/R3/R5 count", rv, ec);
      rd(2'd2, rv); chk("R5 flag", {31'd0, rv[8]}, {31'd0, ef});
      chk("R7 irq", {31'd0, irq}, {31'd0, ef & ie});
    end

    // R4: held while start low
    repeat (50) @(posedge clk);
    rd(2'd1, rv); chk("R4 hold", rv, 32'd0);

    // R8: bit8=1 keeps flag (flag set from last vector), bit8=0 clears
    wr(2'd2, 32'h0000_0120);
    rd(2'd2, rv); chk("R8 keep", rv, 32'h0000_0120);
    chk("R7 irq on", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0000_0020);
    rd(2'd2, rv); chk("R8 clear", rv, 32'h0000_0020);
    chk("R7 irq off", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h0000_0120);
    rd(2'd2, rv); chk("R8 no set", {31'd0, rv[8]}, 32'd0);

    // R9: upper bits ignored
    wr(2'd2, 32'hFFFF_FEFF);
    rd(2'd2, rv); chk("R9 ctrl view", rv, 32'h0000_00FF);

    // R6: reload/count writes, addr 3
    wr(2'd0, 32'h1234_5678); wr(2'd1, 32'hCAFE_0001); wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R6 reload", rv, 32'h1234_5678);
    rd(2'd1, rv); chk("R6 count", rv, 32'hCAFE_0001);
    rd(2'd3, rv); chk("R6 addr3", rv, 32'h0);

    // R11: rdata holds without rd_en
    addr = 2'd0; repeat (3) @(posedge clk); #1;
    chk("R11 hold", rdata, 32'h0);

    // R10: counter write on the underflow edge
    wr(2'd2, 32'h0000_0020);
    wr(2'd0, 32'd9); wr(2'd1, 32'd0);
    @(negedge clk); start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 32'h55;
    @(posedge clk); #1 wr_en = 1'b0; start = 1'b0;
    rd(2'd1, rv); chk("R10 write wins count", rv, 32'h55);
    rd(2'd2, rv); chk("R10 flag set", {31'd0, rv[8]}, 32'd1);

    // R10: clearing ctrl write on the underflow edge
    wr(2'd2, 32'h0000_0020);
    wr(2'd1, 32'd0);
    @(negedge clk); start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 32'h0000_0020;
    @(posedge clk); #1 wr_en = 1'b0; start = 1'b0;
    rd(2'd2, rv); chk("R10 underflow beats clear", {31'd0, rv[8]}, 32'd1);
    rd(2'd1, rv); chk("R10 reload on collision", rv, 32'd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule